// File: doc/BRIEF.md
# Timing Reference Detector and Range Clipper

This block sits in the parallel path of a serial digital video transmitter, between the input word register and the scrambler. It takes one video word per parallel clock. It can also take 8-bit video, which it widens to the 10-bit form. When detection is enabled, it first forces the reserved codes at both ends of the code range to the exact timing-reference values. It then looks for the timing reference sequence that marks the start and the end of active video. Each word leaves the block with a flag for the reference sequence, a flag on the fourth word that tells start from end, and a flag that marks active video words for the encoder downstream.

Detection and clipping are controlled by one active-low enable, so that a board which ties the pin low, or leaves it to a pull-down, gets full processing. With the enable high, the block is a fixed-delay pipe: words pass through unchanged and no flag is raised. The enable is taken together with each word and travels down the pipeline with it. A change of the enable therefore acts on word boundaries, and the delay does not change.

Top module: `trs_clip_top`

## Requirements
- R1: With detection enabled (det_en_n = 0), any 10-bit word from 000h to 003h leaves the block as exactly 000h.
- R2: With detection enabled, any 10-bit word from 3FCh to 3FFh leaves the block as exactly 3FFh.
- R3: With narrow_mode = 1, the 8-bit word is taken from din[9:2] and widened by appending two zero LSBs. The pins din[1:0] have no effect. The widened word is clipped and detected like a 10-bit word.
- R4: With det_en_n = 1 for a word, that word leaves the block unchanged (after widening only), with trs_flag, sav_flag, eav_flag and video_valid all low, at the same latency.
- R5: trs_flag is high on each of four consecutive output words when the first three clipped, enabled words are 3FFh, 000h, 000h. A partial preamble raises no flag.
- R6: On the fourth word of a reference sequence, bit 6 of the word selects the marker: 0 raises sav_flag, 1 raises eav_flag. Neither marker is high on any other word.
- R7: Detection works on clipped words, so a preamble such as 3FEh, 003h, 001h is recognised.
- R8: video_valid is high on every enabled, non-reference word after a start marker, until the next end marker. It is low on reference words. A disabled word also ends the active region.
- R9: Every word and its flags appear at the outputs three clock cycles after the word is sampled.
- R10: While rst_n is low, and until the first word after release has passed, dout is 000h and all flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| det_en_n | input | 1 | Active-low enable for clipping and detection, sampled with each word |
| narrow_mode | input | 1 | Selects 8-bit input on din[9:2] |
| din | input | 10 | Parallel input word |
| dout | output | 10 | Widened and possibly clipped word |
| trs_flag | output | 1 | Word belongs to a timing reference sequence |
| sav_flag | output | 1 | Fourth reference word marks start of active video |
| eav_flag | output | 1 | Fourth reference word marks end of active video |
| video_valid | output | 1 | Word lies in active video |

## Verification
The hardest cases to reach are sequences that only look valid after clipping, and the enable dropping in the middle of an active region. Neither shows up with clean codes or with a static enable. The stimulus builds one long word stream. It mixes reserved-code preambles (3FEh, 003h, 001h) and 8-bit preambles with nonzero low pins. It also contains partial preambles inside active video, and a single disabled word placed between a start marker and the next video word. The expected flags for this stream are worked out ahead of time with lookahead over the whole stream.

// File: rtl/trs_pkg.sv
package trs_pkg;
  // Number of words in one timing reference sequence
  localparam int TRS_LEN = 4;

  typedef struct packed {
    logic trs;
    logic sav;
    logic eav;
    logic vld;
  } trs_flags_t;
endpackage

// File: rtl/trs_word_widen.sv
module trs_word_widen #(
  parameter int WORD_W   = 10,
  parameter int NARROW_W = 8
) (
  input  logic              narrow,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - NARROW_W;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (narrow) word = {raw[WORD_W-1 -: NARROW_W], {PAD_W{1'b0}}};
        else        word = raw;
      end
    end else begin : g_same
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign word = raw;
    end
  endgenerate
endmodule

// File: rtl/trs_range_clip.sv
module trs_range_clip #(
  parameter int WORD_W    = 10,
  parameter int CLIP_SPAN = 4
) (
  input  logic              en,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] TOP_CODE = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] LO_LIM   = WORD_W'(CLIP_SPAN);
  localparam logic [WORD_W-1:0] HI_LIM   = TOP_CODE - WORD_W'(CLIP_SPAN - 1);

  always_comb begin
    word_o = word_i;
    if (en) begin
      if (word_i < LO_LIM)       word_o = '0;
      else if (word_i >= HI_LIM) word_o = TOP_CODE;
    end
  end
endmodule

// File: rtl/trs_marker_track.sv
module trs_marker_track
  import trs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,      // preamble starts at the word being loaded
  input  logic       word_en,  // enable that came with that word
  input  logic       hbit,     // H bit of that word
  output trs_flags_t flags
);
  localparam int IDX_W = $clog2(TRS_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRS_LEN - 1);
  localparam logic [IDX_W-1:0] XYZ_PREV = IDX_W'(TRS_LEN - 2);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             act_q, act_d;
  trs_flags_t       flg_q, flg_d;
  logic             cont;

  always_comb begin
    cont      = flg_q.trs && (idx_q != LAST_IDX);
    flg_d.trs = word_en && (hit || cont);
    flg_d.sav = word_en && cont && (idx_q == XYZ_PREV) && !hbit;
    flg_d.eav = word_en && cont && (idx_q == XYZ_PREV) && hbit;
    flg_d.vld = word_en && act_q && !flg_d.trs;
    idx_d     = (word_en && cont) ? idx_q + 1'b1 : '0;
    if (!word_en)       act_d = 1'b0;
    else if (flg_d.sav) act_d = 1'b1;
    else if (flg_d.eav) act_d = 1'b0;
    else                act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= 1'b0;
      flg_q <= '0;
    end else begin
      idx_q <= idx_d;
      act_q <= act_d;
      flg_q <= flg_d;
    end
  end

  assign flags = flg_q;
endmodule

// File: rtl/trs_clip_top.sv
module trs_clip_top
  import trs_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int NARROW_W  = 8,
  parameter int CLIP_SPAN = 4,
  parameter int H_POS     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en_n,
  input  logic              narrow_mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              trs_flag,
  output logic              sav_flag,
  output logic              eav_flag,
  output logic              video_valid
);
  localparam logic [WORD_W-1:0] HEAD_CODE = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] ZERO_CODE = '0;
  localparam int               SYNC_N    = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  // input conditioning
  logic [WORD_W-1:0] wide_word, clip_word;
  logic              en_in;

  assign en_in = !det_en_n;

  trs_word_widen #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_widen (
    .narrow (narrow_mode),
    .raw    (din),
    .word   (wide_word)
  );

  trs_range_clip #(.WORD_W(WORD_W), .CLIP_SPAN(CLIP_SPAN)) u_clip (
    .en     (en_in),
    .word_i (wide_word),
    .word_o (clip_word)
  );

  // three-stage word pipeline
  logic [WORD_W-1:0] s1_word_q, s1_word_d, s2_word_q, s2_word_d, out_q, out_d;
  logic              s1_en_q, s1_en_d, s2_en_q, s2_en_d;
  logic              pre_hit;

  always_comb begin
    s1_word_d = clip_word;
    s1_en_d   = en_in;
    s2_word_d = s1_word_q;
    s2_en_d   = s1_en_q;
    out_d     = s2_word_q;
    pre_hit   = s2_en_q && s1_en_q && en_in &&
                (s2_word_q == HEAD_CODE) &&
                (s1_word_q == ZERO_CODE) &&
                (clip_word == ZERO_CODE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_word_q <= '0;
      s1_en_q   <= 1'b0;
      s2_word_q <= '0;
      s2_en_q   <= 1'b0;
      out_q     <= '0;
    end else begin
      s1_word_q <= s1_word_d;
      s1_en_q   <= s1_en_d;
      s2_word_q <= s2_word_d;
      s2_en_q   <= s2_en_d;
      out_q     <= out_d;
    end
  end

  trs_flags_t flags;

  trs_marker_track u_track (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hit     (pre_hit),
    .word_en (s2_en_q),
    .hbit    (s2_word_q[H_POS]),
    .flags   (flags)
  );

  assign dout        = out_q;
  assign trs_flag    = flags.trs;
  assign sav_flag    = flags.sav;
  assign eav_flag    = flags.eav;
  assign video_valid = flags.vld;
endmodule

// File: rtl/trs_clip_chk.sv
module trs_clip_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_en_n,
  input logic              narrow_mode,
  input logic [WORD_W-1:0] din,
  input logic [WORD_W-1:0] dout,
  input logic              trs_flag,
  input logic              sav_flag,
  input logic              eav_flag,
  input logic              video_valid
);
  localparam logic [WORD_W-1:0] TOP_CODE = {WORD_W{1'b1}};

  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_cnt <= '0;
    else if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt == 3'd7);

  // R1
  clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $past(!det_en_n && !narrow_mode && (din < WORD_W'(4)), 3) |-> (dout == '0));

  // R2
  clip_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $past(!det_en_n && !narrow_mode && (din > TOP_CODE - WORD_W'(4)), 3) |-> (dout == TOP_CODE));

  // R4
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $past(det_en_n, 3) |-> (!trs_flag && !sav_flag && !eav_flag && !video_valid));

  // R5
  marker_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (sav_flag || eav_flag) |-> (trs_flag && $past(trs_flag, 1) && $past(trs_flag, 2) && $past(trs_flag, 3)));

  // R6
  marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $countones({sav_flag, eav_flag}) <= 1);

  // R8
  valid_not_trs_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    trs_flag |-> !video_valid);

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (dout == '0 && !trs_flag && !sav_flag && !eav_flag && !video_valid);
    end
  end
endmodule

bind trs_clip_top trs_clip_chk #(.WORD_W(WORD_W)) u_trs_clip_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .det_en_n    (det_en_n),
  .narrow_mode (narrow_mode),
  .din         (din),
  .dout        (dout),
  .trs_flag    (trs_flag),
  .sav_flag    (sav_flag),
  .eav_flag    (eav_flag),
  .video_valid (video_valid)
);

// File: tb/test_trs_clip_top.sv
`timescale 1ns/1ps
module test_trs_clip_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n, det_en_n, narrow_mode;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic         trs_flag, sav_flag, eav_flag, video_valid;

  always #2 clk = ~clk;

  trs_clip_top i_trs_clip_top (
    .clk(clk), .rst_n(rst_n), .det_en_n(det_en_n), .narrow_mode(narrow_mode),
    .din(din), .dout(dout), .trs_flag(trs_flag), .sav_flag(sav_flag),
    .eav_flag(eav_flag), .video_valid(video_valid)
  );

  typedef struct {
    logic [W-1:0] d;
    logic         en_n;
    logic         nar;
    string        tag;
  } stim_t;

  typedef struct {
    logic [W-1:0] w;
    logic         trs, sav, eav, vv;
    string        tag;
    int           stamp;
  } exp_t;

  stim_t stim[$];
  exp_t  expv[$];
  exp_t  sb[$];
  int    checks = 0, fails = 0, cyc = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic add(input logic [W-1:0] d, input logic en_n, input logic nar, input string tag);
    stim_t s;
    s.d = d; s.en_n = en_n; s.nar = nar; s.tag = tag;
    stim.push_back(s);
  endtask

  function automatic logic [W-1:0] widen(input logic [W-1:0] d, input logic nar);
    return nar ? {d[9:2], 2'b00} : d;
  endfunction

  function automatic logic [W-1:0] clipw(input logic [W-1:0] w);
    if (w <= 10'h003) return 10'h000;
    if (w >= 10'h3FC) return 10'h3FF;
    return w;
  endfunction

  // expected results from the requirements, with lookahead over the stream
  task automatic build_expect();
    logic [W-1:0] c[$];
    logic         en[$];
    logic         trs = 0, act = 0;
    int           idx = 0;
    int           n = stim.size();
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w = widen(stim[i].d, stim[i].nar);
      en.push_back(!stim[i].en_n);
      c.push_back(!stim[i].en_n ? clipw(w) : w);
    end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic pre, cont, ntrs, nsav, neav, nvv;
      pre  = (i + 2 < n) && en[i] && en[i+1] && en[i+2] &&
             c[i] == 10'h3FF && c[i+1] == 10'h000 && c[i+2] == 10'h000;
      cont = trs && idx != 3;
      ntrs = en[i] && (pre || cont);
      nsav = en[i] && cont && idx == 2 && !c[i][6];
      neav = en[i] && cont && idx == 2 && c[i][6];
      nvv  = en[i] && act && !ntrs;
      idx  = (en[i] && cont) ? idx + 1 : 0;
      act  = !en[i] ? 1'b0 : nsav ? 1'b1 : neav ? 1'b0 : act;
      trs  = ntrs;
      e.w = c[i]; e.trs = ntrs; e.sav = nsav; e.eav = neav; e.vv = nvv;
      e.tag = stim[i].tag; e.stamp = 0;
      expv.push_back(e);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (dout !== 10'h000 || trs_flag || sav_flag || eav_flag || video_valid) begin
      fails++;
      $display("FAIL %s: dout=%h flags=%b%b%b%b expected dout=000 flags=0000",
               tag, dout, trs_flag, sav_flag, eav_flag, video_valid);
    end
  endtask

  // scoreboard monitor: R9 alignment is three edges after the drive point
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].stamp + 3 <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.stamp + 3 != cyc || dout !== e.w || trs_flag !== e.trs || sav_flag !== e.sav ||
          eav_flag !== e.eav || video_valid !== e.vv) begin
        fails++;
        $display("FAIL %s: dout=%h trs/sav/eav/vld=%b%b%b%b expected dout=%h %b%b%b%b",
                 e.tag, dout, trs_flag, sav_flag, eav_flag, video_valid,
                 e.w, e.trs, e.sav, e.eav, e.vv);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; det_en_n = 1'b1; narrow_mode = 1'b0; din = '0;
    #1 rst_n = 1'b0;
    din = 10'h3FF; det_en_n = 1'b0;
    repeat (3) @(negedge clk) check_idle("R10 in reset");
    det_en_n = 1'b1; din = '0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk) check_idle("R10 after release");

    add(10'h000, 1, 0, "R4 idle");   add(10'h000, 1, 0, "R4 idle");
    // R1 low clip and its boundary
    add(10'h001, 0, 0, "R1"); add(10'h002, 0, 0, "R1"); add(10'h003, 0, 0, "R1");
    add(10'h004, 0, 0, "R1 edge"); add(10'h123, 0, 0, "R1");
    // R2 high clip and its boundary
    add(10'h3FC, 0, 0, "R2"); add(10'h3FD, 0, 0, "R2"); add(10'h3FE, 0, 0, "R2");
    add(10'h3FB, 0, 0, "R2 edge"); add(10'h3FF, 0, 0, "R2"); add(10'h155, 0, 0, "R2");
    // start marker, active video, end marker
    add(10'h3FF, 0, 0, "R5"); add(10'h000, 0, 0, "R5"); add(10'h000, 0, 0, "R5");
    add(10'h200, 0, 0, "R6 sav");
    add(10'h155, 0, 0, "R8"); add(10'h2AA, 0, 0, "R8"); add(10'h3FC, 0, 0, "R8 R2");
    add(10'h100, 0, 0, "R8");
    add(10'h3FF, 0, 0, "R5"); add(10'h000, 0, 0, "R5"); add(10'h000, 0, 0, "R5");
    add(10'h274, 0, 0, "R6 eav"); add(10'h080, 0, 0, "R8 after eav");
    // preamble made of reserved codes, then a partial preamble inside video
    add(10'h3FE, 0, 0, "R7"); add(10'h003, 0, 0, "R7"); add(10'h001, 0, 0, "R7");
    add(10'h31C, 0, 0, "R7 sav"); add(10'h1A0, 0, 0, "R8");
    add(10'h3FF, 0, 0, "R5 partial"); add(10'h000, 0, 0, "R5 partial");
    add(10'h0AB, 0, 0, "R5 partial");
    add(10'h3FF, 0, 0, "R5"); add(10'h000, 0, 0, "R5"); add(10'h000, 0, 0, "R5");
    add(10'h274, 0, 0, "R6 eav"); add(10'h0AA, 0, 0, "R8");
    // 8-bit input with the low pins driven
    add(10'h3FF, 0, 1, "R3"); add(10'h001, 0, 1, "R3"); add(10'h002, 0, 1, "R3");
    add(10'h202, 0, 1, "R3 sav"); add(10'h157, 0, 1, "R3 R8");
    add(10'h3FD, 0, 1, "R3"); add(10'h000, 0, 1, "R3"); add(10'h003, 0, 1, "R3");
    add(10'h1D1, 0, 1, "R3 eav");
    // disabled: raw pass-through, no flags
    add(10'h3FF, 1, 0, "R4"); add(10'h000, 1, 0, "R4"); add(10'h000, 1, 0, "R4");
    add(10'h200, 1, 0, "R4"); add(10'h001, 1, 0, "R4"); add(10'h3FD, 1, 0, "R4");
    add(10'h155, 1, 0, "R4");
    // one disabled word inside active video ends it
    add(10'h3FF, 0, 0, "R5"); add(10'h000, 0, 0, "R5"); add(10'h000, 0, 0, "R5");
    add(10'h200, 0, 0, "R6 sav"); add(10'h111, 0, 0, "R8");
    add(10'h222, 1, 0, "R4 R8"); add(10'h333, 0, 0, "R8 ended");
    add(10'h2B5, 0, 0, "R9");
    repeat (4) add(10'h000, 1, 0, "R4 idle");

    build_expect();
    for (int i = 0; i < stim.size(); i++) begin
      exp_t e;
      @(negedge clk);
      din = stim[i].d; det_en_n = stim[i].en_n; narrow_mode = stim[i].nar;
      e = expv[i];
      e.stamp = cyc;
      sb.push_back(e);
    end
    repeat (6) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule